// File: doc/BRIEF.md
# Clocked Row Delay Line with Optional Difference Output

This block delays a stream of 24-bit samples by a whole number of clock cycles using a single 1024-word RAM. An internal address counter supplies the RAM address on every cycle. At that address the old word is read out and the new sample is written in its place. The delay is not stored in any register. It follows from how often the active-low `start_n` input restarts the counter, plus a fixed four-cycle pipeline. If `start_n` is pulsed low once every P cycles, a sample leaves the block P+4 cycles after it went in. A mode input switches the output from a plain delayed copy to the delayed sample minus the sample arriving now, for example a pixel minus the pixel one row later.

The counter is a two-state machine. State `CNT_HOLD` parks the address at the top word (1023) with RAM writes off. State `CNT_RUN` advances the address by one each cycle with writes on.
- Reset enters `CNT_HOLD`.
- The *restart* transition (any state to `CNT_RUN`, address 0) is taken whenever the registered `start_n` is low.
- The *step* transition (`CNT_RUN` to `CNT_RUN`) adds one to the address.
- The *saturate* transition (`CNT_RUN` to `CNT_HOLD`) is taken when the address moves from 1022 to 1023.
- The *park* transition (`CNT_HOLD` to `CNT_HOLD`) keeps the address at 1023.

Top module: `row_delay_line`

## Requirements
- R1: While `rst_n` is low, `dout` is zero.
- R2: After reset and before the first low `start_n`, the counter is parked at address 1023 and nothing is written to the RAM. In delay mode `dout` then stays constant while `din` changes.
- R3: A sample presented with `start_n` low is stored at address 0. Each later sample presented with `start_n` high is stored at the next address. Restarting with a different period takes effect from that sample on.
- R4: With `mode_sub` = 0 and `start_n` low once every P cycles (P ≥ 1), a sample on `din` appears on `dout` P+4 cycles later. Counted in clock edges: the sample taken at edge k is shown on `dout` from edge k+P+3.
- R5: With `mode_sub` = 1, `dout` equals the stored sample minus the incoming sample that shares its address, modulo 2^24. There is no saturation and no overflow flag.
- R6: A read and a write to the same address in the same cycle return the old word. With P = 1 the block is therefore a five-cycle delay.
- R7: In `CNT_RUN` the counter stops at 1023 and holds there. Writes are disabled at address 1023 until the next restart, so `dout` (delay mode), or `dout` plus the incoming sample (subtract mode), stays constant.
- R8: `mode_sub` is taken together with the incoming sample. Each output word uses the mode that came in with the sample being subtracted, so toggling the mode every cycle alternates the output form word by word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low row restart; resets the address counter to 0 |
| mode_sub | input | 1 | 0: plain delay, 1: stored minus incoming |
| din | input | 24 | Incoming sample |
| dout | output | 24 | Delayed sample or difference |

## Verification
The main function is driven through a table of row periods (1, 2, 6, 13 and others) with ramp data of different slopes. An off-by-one in the pipeline or counter shows up as the wrong sample, and P = 1 isolates read-before-write behaviour. Subtract rows are chosen so that results both wrap below zero and wrap past the top of the 24-bit range. A row with `mode_sub` toggled every cycle separates mode alignment to the incoming sample from alignment to the stored one. Long runs without restart, before the first restart and past address 1023, show that writes stay off while the address is parked.

// File: rtl/rdl_pkg.sv
`timescale 1ns/1ps
package rdl_pkg;

    // Address counter states
    typedef enum logic [0:0] {
        CNT_HOLD = 1'b0,   // parked at top address, writes off
        CNT_RUN  = 1'b1    // stepping, writes on
    } cnt_state_e;

    // Register stages from a pin to the RAM read data:
    // input register, address register, RAM read register
    localparam int unsigned RD_STAGES = 3;

endpackage

// File: rtl/rdl_align.sv
`timescale 1ns/1ps
// Fixed-depth register chain used to keep side-band data in step with the RAM path
module rdl_align #(
    parameter int unsigned W       = 1,
    parameter int unsigned STAGES  = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) pipe_q[i] <= RST_VAL;
        end else begin
            pipe_q[0] <= d_i;
            for (int i = 1; i < int'(STAGES); i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/rdl_addr_fsm.sv
`timescale 1ns/1ps
// Row address counter: restart to zero, step, saturate at top
module rdl_addr_fsm
    import rdl_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart_n,   // registered start, active low
    output logic [ADDR_W-1:0] addr_o,
    output logic              wr_en_o
);

    localparam logic [ADDR_W-1:0] TOP     = '1;
    localparam logic [ADDR_W-1:0] PRE_TOP = TOP - 1'b1;

    cnt_state_e        state_q, state_d;
    logic [ADDR_W-1:0] addr_q, addr_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CNT_HOLD;
            addr_q  <= TOP;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        if (!restart_n) begin
            state_d = CNT_RUN;            // restart
            addr_d  = '0;
        end else begin
            unique case (state_q)
                CNT_RUN: begin
                    addr_d = addr_q + 1'b1;   // step
                    if (addr_q == PRE_TOP)
                        state_d = CNT_HOLD;   // saturate
                end
                CNT_HOLD: begin
                    addr_d = TOP;             // park
                end
                default: begin
                    state_d = CNT_HOLD;
                    addr_d  = TOP;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        addr_o  = addr_q;
        wr_en_o = (state_q == CNT_RUN);
    end

    // R3: a restart puts the counter at zero in the running state
    a_r3_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_n |=> (addr_q == '0 && state_q == CNT_RUN));

    // R3: without restart, a running counter advances by one
    a_r3_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_n && state_q == CNT_RUN) |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1)));

    // R7: a parked counter stays parked at the top until restarted
    a_r7_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
        (restart_n && state_q == CNT_HOLD) |=> (state_q == CNT_HOLD && addr_q == TOP));

endmodule

// File: rtl/rdl_ram.sv
`timescale 1ns/1ps
// Synchronous RAM, one address, read-before-write
module rdl_ram #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int unsigned   DEPTH = 1 << ADDR_W;
    localparam logic [ADDR_W-1:0] TOP = '1;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem[addr_i] <= wdata_i;
    end

    // old word is returned when the same address is written in this cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_o <= '0;
        else        rdata_o <= mem[addr_i];
    end

    // R7: the top word is never written
    a_r7_no_write_at_top: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (addr_i != TOP));

endmodule

// File: rtl/rdl_out_stage.sv
`timescale 1ns/1ps
// Output register: stored word, or stored minus incoming (wrapping)
module rdl_out_stage #(
    parameter int unsigned DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] stored_i,
    input  logic [DATA_W-1:0] incoming_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] dout_o
);

    logic [DATA_W-1:0] diff;

    assign diff = stored_i - incoming_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dout_o <= '0;
        else if (sub_i) dout_o <= diff;
        else            dout_o <= stored_i;
    end

endmodule

// File: rtl/row_delay_line.sv
`timescale 1ns/1ps
module row_delay_line
    import rdl_pkg::*;
#(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_n,
    input  logic              mode_sub,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    localparam int unsigned SIDE_W = DATA_W + 1;

    logic              start_q;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] wr_data;
    logic [SIDE_W-1:0] side_in, side_at_ram, side_at_out;

    assign side_in = {mode_sub, din};

    // start pin register
    rdl_align #(.W(1), .STAGES(1), .RST_VAL(1'b1)) u_start_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (start_n),
        .q_o   (start_q)
    );

    rdl_addr_fsm #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_n (start_q),
        .addr_o    (addr),
        .wr_en_o   (wr_en)
    );

    // sample and mode reach the RAM port together with their address
    rdl_align #(.W(SIDE_W), .STAGES(RD_STAGES - 1)) u_side_to_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (side_in),
        .q_o   (side_at_ram)
    );

    assign wr_data = side_at_ram[DATA_W-1:0];

    rdl_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (addr),
        .we_i    (wr_en),
        .wdata_i (wr_data),
        .rdata_o (rd_data)
    );

    // one more stage so the incoming sample lines up with the read word
    rdl_align #(.W(SIDE_W), .STAGES(1)) u_side_to_out (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (side_at_ram),
        .q_o   (side_at_out)
    );

    rdl_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .stored_i   (rd_data),
        .incoming_i (side_at_out[DATA_W-1:0]),
        .sub_i      (side_at_out[DATA_W]),
        .dout_o     (dout)
    );

endmodule

// File: tb/row_delay_line_bench.sv
`timescale 1ns/1ps
module row_delay_line_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_n;
    logic        mode_sub;
    logic [23:0] din;
    logic [23:0] dout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    row_delay_line u_row_delay_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_n  (start_n),
        .mode_sub (mode_sub),
        .din      (din),
        .dout     (dout)
    );

    // kind: 0 delay, 1 subtract, 2 mode toggled every sample
    typedef struct packed {
        logic [4:0]  period;
        logic [1:0]  kind;
        logic [23:0] seed;
        logic [23:0] stp;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VECS [NVEC] = '{
        '{5'd6,  2'd0, 24'h000100, 24'h000013},   // ten-cycle delay
        '{5'd1,  2'd0, 24'hABCDEF, 24'h010203},   // same address every cycle
        '{5'd13, 2'd0, 24'h7FFFF0, 24'h00000B},
        '{5'd6,  2'd1, 24'h000050, 24'h000007},   // differences below zero
        '{5'd4,  2'd1, 24'hFFFFF0, 24'hFFFFFD},   // values wrap past the top
        '{5'd5,  2'd2, 24'h123456, 24'h0F0F0F},
        '{5'd2,  2'd0, 24'h400000, 24'h3FFFFF}
    };

    logic [23:0] xh [0:2047];
    logic        mh [0:2047];

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, pass one rising edge, come back to the falling edge
    task automatic step(input logic [23:0] x, input logic s, input logic m);
        din      = x;
        start_n  = s;
        mode_sub = m;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [23:0] hold;
        rst_n    = 1'b0;
        start_n  = 1'b1;
        mode_sub = 1'b0;
        din      = 24'h5A5A5A;
        @(negedge clk);
        step(24'h111111, 1'b0, 1'b1);
        step(24'h222222, 1'b1, 1'b1);
        check("R1 in reset", dout, 24'h0);
        rst_n = 1'b1;

        // R2: no restart yet, address parked, no writes
        hold = '0;
        for (int k = 0; k < 14; k++) begin
            step(24'(k * 24'h111111 + 5), 1'b1, 1'b0);
            if (k == 4) hold = dout;
            if (k > 4)  check("R2 parked before first start", dout, hold);
        end

        // table of rows
        for (int v = 0; v < NVEC; v++) begin
            int    p;
            int    len;
            string tag;
            p   = int'(VECS[v].period);
            len = p + 3 + 12;
            if (VECS[v].kind == 2'd1)      tag = "R5";
            else if (VECS[v].kind == 2'd2) tag = "R8";
            else if (p == 1)               tag = "R6";
            else                           tag = "R3/R4";
            for (int k = 0; k < len; k++) begin
                logic [23:0] x;
                logic        m;
                logic [23:0] exp;
                x = 24'(VECS[v].seed + 24'(k) * VECS[v].stp);
                m = (VECS[v].kind == 2'd1) ? 1'b1 :
                    (VECS[v].kind == 2'd2) ? 1'(k % 2) : 1'b0;
                xh[k] = x;
                mh[k] = m;
                step(x, (k % p) != 0, m);
                if (k >= p + 3) begin
                    exp = xh[k-p-3] - (mh[k-3] ? xh[k-3] : 24'h0);
                    check(tag, dout, exp);
                end
            end
        end

        // R7: one restart, then run past the top address
        hold = '0;
        for (int k = 0; k < 1054; k++) begin
            logic [23:0] x;
            logic        m;
            x = 24'(k * 24'h00A5A5 + 3);
            m = (k >= 1040);
            xh[k] = x;
            step(x, k != 0, m);
            if (k == 1029) hold = dout;
            if (k > 1029 && k < 1040)
                check("R7 saturated delay output", dout, hold);
            if (k >= 1043)
                check("R7 saturated subtract output", 24'(dout + xh[k-3]), hold);
        end

        // R1 again: reset in the middle of traffic
        din = 24'hFEDCBA;
        rst_n = 1'b0;
        #1;
        check("R1 reset mid-run", dout, 24'h0);
        @(negedge clk);
        check("R1 held in reset", dout, 24'h0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule